// File: doc/BRIEF.md
# Pseudorandom Watchdog Key Sequencer

This block checks the keyed service sequence that software writes to a watchdog. Fixed service constants are not used. Each expected key is the next output of a 16-bit linear congruential generator: new = (17 * old + 3) mod 65536. The generator state is held in a register. Software can read that register and seed it. A complete service is two matching keys written one after the other. The generator advances to the written value each time a key is accepted, so the next pair of keys differs from the last pair.

A service write is taken only while keyed mode is enabled and no seed load is present in the same cycle. The outputs are registered:

- The accepted pulse and the invalid pulse appear in the cycle after the write.
- The new generator state is visible in the cycle after the write or seed load.

Timeout counting, service windows and bus-error signalling belong to the surrounding watchdog.

Top module: `svc_key_seq`

## Requirements
- R1: A synchronous active-low reset sets the generator state to 0x0000. It places the tracker at its first step and holds `svc_ok` and `key_bad` low.
- R2: The key expected by a write equals (17 * S + 3) mod 65536, where S is the value on `gen_state`. Starting from state 0x0100, the keys 0x1103, 0x2136, 0x3499 and 0x7E2C are accepted in that order.
- R3: A taken write whose data equals the expected key sets `gen_state` to the written data in the next cycle.
- R4: A taken write whose data differs from the expected key raises `key_bad` for one cycle in the next cycle. It leaves `gen_state` unchanged and returns the tracker to its first step.
- R5: `svc_ok` is high for one cycle, in the cycle after a matching key that follows a matching first key. A matching first key alone gives no pulse.
- R6: `svc_ok` and `key_bad` are never high in the same cycle. Neither stays high for two consecutive cycles unless a new taken write arrives.
- R7: A seed load sets `gen_state` to `seed_val` in the next cycle and returns the tracker to its first step. A service write in the same cycle is ignored and produces no pulse.
- R8: While `keyed_en` is low, service writes have no effect. No pulse is produced, and the state and tracker position are kept.
- R9: Starting from any seed, 65536 successive accepted keys visit every 16-bit value exactly once and then return to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keyed_en | input | 1 | Keyed service mode enable |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 16 | Service write data (key) |
| seed_ld | input | 1 | Seed load strobe for the generator state |
| seed_val | input | 16 | Seed value |
| svc_ok | output | 1 | One-cycle pulse: full two-key service accepted |
| key_bad | output | 1 | One-cycle pulse: written key did not match |
| gen_state | output | 16 | Current generator state |

## Verification
The assertions assume that reset is held low for at least one clock edge before any property is evaluated. They also assume that inputs are stable around the rising edge, so each strobe counts exactly once per cycle. The bench keeps to these assumptions in three ways:

- It drives every input on the falling edge.
- It holds all strobes idle while reset is low.
- It asserts reset for several cycles both at start-up and in the middle of the run.

The bench also covers the seed-versus-write priority, which the assertions check directly, by issuing a seed load in the same cycle as a write.

// File: rtl/svc_key_pkg.sv
package svc_key_pkg;

    typedef enum logic {
        STEP_FIRST  = 1'b0,
        STEP_SECOND = 1'b1
    } key_step_e;

    typedef struct packed {
        key_step_e step;
        logic      ok;
        logic      bad;
    } trk_reg_t;

endpackage

// File: rtl/svc_key_lcg.sv
// Combinational next-value function of the key generator.
// When MULT-1 is a power of two, the product becomes a shift plus an add.
module svc_key_lcg #(
    parameter int W    = 16,
    parameter int MULT = 17,
    parameter int INC  = 3
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] MULT_C      = W'(MULT);
    localparam logic [W-1:0] INC_C       = W'(INC);
    localparam bit           SHIFT_FORM  = (MULT > 1) && (((MULT - 1) & (MULT - 2)) == 0);
    localparam int           SH          = (MULT > 1) ? $clog2(MULT - 1) : 0;

    generate
        if (SHIFT_FORM) begin : g_shift_add
            always_comb begin
                nxt_o = (cur_i << SH) + cur_i + INC_C;
            end
        end else begin : g_mult
            always_comb begin
                nxt_o = (cur_i * MULT_C) + INC_C;
            end
        end
    endgenerate
endmodule

// File: rtl/svc_key_track.sv
// Tracks progress through the two-key pair and produces the result pulses.
module svc_key_track
    import svc_key_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      try_i,
    input  logic      hit_i,
    input  logic      seed_i,
    output key_step_e step_o,
    output logic      ok_o,
    output logic      bad_o
);
    trk_reg_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.ok   = 1'b0;
        trk_d.bad  = 1'b0;
        if (seed_i) begin
            trk_d.step = STEP_FIRST;
        end else if (try_i) begin
            if (!hit_i) begin
                trk_d.bad  = 1'b1;
                trk_d.step = STEP_FIRST;
            end else if (trk_q.step == STEP_SECOND) begin
                trk_d.ok   = 1'b1;
                trk_d.step = STEP_FIRST;
            end else begin
                trk_d.step = STEP_SECOND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{step: STEP_FIRST, ok: 1'b0, bad: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign step_o = trk_q.step;
    assign ok_o   = trk_q.ok;
    assign bad_o  = trk_q.bad;
endmodule

// File: rtl/svc_key_seq.sv
module svc_key_seq
    import svc_key_pkg::*;
#(
    parameter int W    = 16,
    parameter int MULT = 17,
    parameter int INC  = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         keyed_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         seed_ld,
    input  logic [W-1:0] seed_val,
    output logic         svc_ok,
    output logic         key_bad,
    output logic [W-1:0] gen_state
);
    typedef struct packed {
        logic [W-1:0] state;
    } gen_reg_t;

    gen_reg_t     gen_d, gen_q;
    logic [W-1:0] key_exp;
    logic         wr_take;
    logic         key_hit;
    key_step_e    trk_step;

    svc_key_lcg #(.W(W), .MULT(MULT), .INC(INC)) u_lcg (
        .cur_i (gen_q.state),
        .nxt_o (key_exp)
    );

    assign wr_take = wr_en && keyed_en && !seed_ld;
    assign key_hit = (wr_data == key_exp);

    svc_key_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .try_i  (wr_take),
        .hit_i  (key_hit),
        .seed_i (seed_ld),
        .step_o (trk_step),
        .ok_o   (svc_ok),
        .bad_o  (key_bad)
    );

    always_comb begin
        gen_d = gen_q;
        if (seed_ld) begin
            gen_d.state = seed_val;
        end else if (wr_take && key_hit) begin
            gen_d.state = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q.state <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign gen_state = gen_q.state;
endmodule

// File: rtl/svc_key_seq_chk.sv
module svc_key_seq_chk
    import svc_key_pkg::*;
#(
    parameter int W    = 16,
    parameter int MULT = 17,
    parameter int INC  = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         keyed_en,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         seed_ld,
    input logic [W-1:0] seed_val,
    input logic         svc_ok,
    input logic         key_bad,
    input logic [W-1:0] gen_state,
    input key_step_e    trk_step
);
    logic [2*W-1:0] wide_next;
    logic [W-1:0]   chk_key;
    logic           chk_take;

    assign wide_next = {{W{1'b0}}, gen_state} * MULT + INC;
    assign chk_key   = wide_next[W-1:0];
    assign chk_take  = wr_en && keyed_en && !seed_ld;

    // R3: accepted key becomes the new state
    assert_good_key_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_take && wr_data == chk_key) |=> (gen_state == $past(wr_data) && !key_bad));

    // R4: mismatch keeps state
    assert_bad_key_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_take && wr_data != chk_key) |=> (key_bad && gen_state == $past(gen_state) && trk_step == STEP_FIRST));

    // R5: accepted pulse only after a second step
    assert_ok_after_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_take && wr_data == chk_key && trk_step == STEP_FIRST) |=> !svc_ok);

    // R6: pulses exclusive and one cycle
    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_ok && key_bad));
    assert_ok_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && !chk_take) |=> !svc_ok);

    // R7: seed load wins over write
    assert_seed_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ld |=> (gen_state == $past(seed_val) && !svc_ok && !key_bad && trk_step == STEP_FIRST));

    // R8: writes ignored outside keyed mode
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_take && !seed_ld) |=> ($stable(gen_state) && $stable(trk_step) && !svc_ok && !key_bad));
endmodule

bind svc_key_seq svc_key_seq_chk #(.W(W), .MULT(MULT), .INC(INC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .keyed_en  (keyed_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .seed_ld   (seed_ld),
    .seed_val  (seed_val),
    .svc_ok    (svc_ok),
    .key_bad   (key_bad),
    .gen_state (gen_state),
    .trk_step  (trk_step)
);

// File: tb/svc_key_seq_tb.sv
`timescale 1ns/1ps
module svc_key_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        keyed_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        seed_ld = 1'b0;
    logic [15:0] seed_val = '0;
    logic        svc_ok;
    logic        key_bad;
    logic [15:0] gen_state;

    int n_cmp  = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [15:0] m_state = '0;
    bit          m_second = 0;
    logic        e_ok = 1'b0;
    logic        e_bad = 1'b0;
    string       pend_tag = "R1";
    bit          seen [65536];

    always #4 clk = ~clk;

    svc_key_seq u_dut (
        .clk(clk), .rst_n(rst_n), .keyed_en(keyed_en), .wr_en(wr_en),
        .wr_data(wr_data), .seed_ld(seed_ld), .seed_val(seed_val),
        .svc_ok(svc_ok), .key_bad(key_bad), .gen_state(gen_state)
    );

    function automatic logic [15:0] nk(input logic [15:0] s);
        int unsigned v;
        v = (17 * int'(s) + 3) % 65536;
        return v[15:0];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_pending();
        chk(pend_tag, "gen_state", int'(gen_state), int'(m_state));
        chk(pend_tag, "svc_ok", int'(svc_ok), int'(e_ok));
        chk(pend_tag, "key_bad", int'(key_bad), int'(e_bad));
    endtask

    // one cycle: check the previous operation, drive a new one, update the model
    task automatic step(input logic we, input logic [15:0] d, input logic ke,
                        input logic sl, input logic [15:0] sv, input string tag);
        @(negedge clk);
        check_pending();
        wr_en = we; wr_data = d; keyed_en = ke; seed_ld = sl; seed_val = sv;
        e_ok = 1'b0; e_bad = 1'b0;
        if (sl) begin
            m_state = sv; m_second = 0;
        end else if (we && ke) begin
            if (d == nk(m_state)) begin
                m_state = d;
                if (m_second) begin e_ok = 1'b1; m_second = 0; end
                else m_second = 1;
            end else begin
                e_bad = 1'b1; m_second = 0;
            end
        end
        pend_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0, 1'b1, 1'b0, 16'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_pending();
        rst_n = 1'b0; wr_en = 0; seed_ld = 0; keyed_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_state = '0; m_second = 0; e_ok = 0; e_bad = 0; pend_tag = "R1";
        chk("R1", "gen_state after reset", int'(gen_state), 0);
        chk("R1", "svc_ok after reset", int'(svc_ok), 0);
        chk("R1", "key_bad after reset", int'(key_bad), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1: tracker at first step after reset: key from state 0 is 0x0003
        step(1, nk(16'h0), 1, 0, 0, "R5 first key no pulse");
        step(1, nk(m_state), 1, 0, 0, "R5 second key pulse");
        idle("R6 pulse drops");

        // R2: known sequence from 0x0100
        step(0, 0, 1, 1, 16'h0100, "R7 seed load");
        step(1, 16'h1103, 1, 0, 0, "R2 key 0x1103");
        chk("R2", "model key", int'(nk(16'h0100)), 16'h1103);
        step(1, 16'h2136, 1, 0, 0, "R2 key 0x2136");
        step(1, 16'h3499, 1, 0, 0, "R2 key 0x3499");
        step(1, 16'h7E2C, 1, 0, 0, "R2 key 0x7E2C");
        idle("R6 idle after pair");

        // R4: mismatch on first and on second step
        step(1, nk(m_state) ^ 16'h0001, 1, 0, 0, "R4 bad first key");
        step(1, nk(m_state), 1, 0, 0, "R3 good key after bad");
        step(1, 16'hFFFF ^ nk(m_state), 1, 0, 0, "R4 bad second key");
        step(1, nk(m_state), 1, 0, 0, "R4 tracker restarted");
        step(1, nk(m_state), 1, 0, 0, "R5 pulse after restart");

        // R8: keyed mode off
        step(1, nk(m_state), 1, 0, 0, "R3 first key");
        step(1, nk(m_state), 0, 0, 0, "R8 matching key ignored");
        step(1, 16'h5A5A, 0, 0, 0, "R8 wrong key ignored");
        step(1, nk(m_state), 1, 0, 0, "R8 tracker kept at second step");

        // R7: seed with simultaneous write, then tracker at first step
        step(1, nk(m_state), 1, 0, 0, "R3 first key before seed");
        step(1, nk(m_state), 1, 1, 16'hABCD, "R7 seed beats write");
        step(1, nk(16'hABCD), 1, 0, 0, "R7 first key after seed");
        step(1, nk(m_state), 1, 0, 0, "R7 pulse on second after seed");

        // R1: mid-run reset
        step(1, nk(m_state), 1, 0, 0, "R3 first key before reset");
        do_reset();
        step(1, nk(16'h0), 1, 0, 0, "R1 tracker first after reset");
        idle("R1 no pulse");

        // R9: full period sweep from seed 0x1234
        step(0, 0, 1, 1, 16'h1234, "R7 sweep seed");
        for (int i = 0; i < 65536; i++) begin
            if (seen[int'(m_state)]) begin
                n_fail++;
                $display("FAIL R9 repeat at step %0d: actual 0x%0h expected unseen", i, m_state);
            end
            n_cmp++;
            seen[int'(m_state)] = 1;
            step(1, nk(m_state), 1, 0, 0, "R9 sweep");
        end
        idle("R9 sweep end");
        @(negedge clk);
        check_pending();
        chk("R9", "state after full period", int'(gen_state), 16'h1234);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule